// File: doc/BRIEF.md
# Load/Store Unit with Alignment Traps

This block executes the immediate-format memory instructions of a small 32-bit register machine. Each instruction names a base register, a data register and a signed 16-bit offset. The unit adds the base value to the sign-extended offset to form a byte address in a 4096-byte data memory. It then issues a byte, halfword or word read or write on a synchronous memory port with per-byte lane enables. Loaded bytes and halfwords are zero-extended before they go to the register file. The move-immediate instruction uses the same format and writes the sign-extended offset straight into the data register.

An access whose address does not suit its size raises a one-cycle misalignment trap. In that case the unit neither touches memory nor writes a register. The register file sits outside the block. The unit presents the two source indices combinationally from the instruction word and gets the values back in the same cycle. All register writes leave through one registered write port, in issue order, and the unit accepts a new instruction on every clock.

Top module: `lsu_core`

## Requirements
- R1: The opcode is bits 31:26 of the instruction, the base index is bits 25:21 and the data index is bits 20:16. Both indices appear on `rf_base_idx` / `rf_data_idx` in the same cycle as the instruction word.
- R2: The byte address is the base value plus bits 15:0 sign-extended (0x8000 and up are negative). Only its low 12 bits count, so addresses wrap inside 4 KB. The word address `mem_addr` is bits 11:2 of that sum, and the request appears one cycle after the instruction is accepted.
- R3: Opcode 16 writes the sign-extended immediate into the data register. It makes no memory request and raises no trap.
- R4: Opcode 17 loads the byte at lane addr[1:0] of the little-endian word and zero-extends it to 32 bits.
- R5: Opcode 18 loads the halfword at lanes addr[1:0] and addr[1:0]+1 and zero-extends it. Opcode 19 loads the whole word.
- R6: Opcodes 20, 21 and 22 store the low 8 bits, the low 16 bits or all 32 bits of the data register. The data is placed on the lanes that start at addr[1:0], and `mem_be` enables exactly those lanes.
- R7: A halfword access with address bit 0 set, or a word access with either of the two low address bits set, pulses `trap_misalign` one cycle after acceptance. It makes no memory request and no register write.
- R8: Opcodes outside 16..22, and any cycle with `instr_valid` low, cause no request, no trap and no register write.
- R9: While `rst` is high, every registered output is driven to zero.
- R10: One instruction can be accepted on every cycle. Register writes arrive in issue order, two cycles after the memory-request cycle. A load issued right after a store to the same word returns the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Immediate-format instruction |
| rf_base_idx | output | 5 | Register-file read index for the base register |
| rf_data_idx | output | 5 | Register-file read index for the data register |
| rf_base_val | input | 32 | Base register value (same cycle) |
| rf_data_val | input | 32 | Data register value (same cycle) |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_idx | output | 5 | Register write index |
| rf_wr_val | output | 32 | Register write value |
| mem_en | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_be | output | 4 | Byte lane enables |
| mem_addr | output | 10 | Word address |
| mem_wdata | output | 32 | Write data, lane aligned |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| trap_misalign | output | 1 | Misaligned access trap pulse |

## Verification
The register indices are checked in the cycle the instruction is driven. The memory request and the trap pulse are due just after the edge that accepts the instruction. A register write is due two edges later, because the memory returns data one cycle after it sees the request. For every driven cycle the driver queues one expected request/trap item, plus a write item that carries its due cycle. The monitor, which samples shortly after each rising edge, pops one request item per cycle and matches each write strobe against the head of the write queue and its due cycle. A write that has not appeared by its due cycle is a failure.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int RIDX_W  = 5;
  localparam int IMM_W   = 16;

  localparam logic [OPC_W-1:0] OPC_MOVI = 6'd16;
  localparam logic [OPC_W-1:0] OPC_LDB  = 6'd17;
  localparam logic [OPC_W-1:0] OPC_LDH  = 6'd18;
  localparam logic [OPC_W-1:0] OPC_LDW  = 6'd19;
  localparam logic [OPC_W-1:0] OPC_STB  = 6'd20;
  localparam logic [OPC_W-1:0] OPC_STH  = 6'd21;
  localparam logic [OPC_W-1:0] OPC_STW  = 6'd22;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } lsu_size_e;

  typedef struct packed {
    logic      is_mov;
    logic      is_load;
    logic      is_store;
    lsu_size_e size;
  } lsu_kind_t;
endpackage

// File: rtl/lsu_decode.sv
`timescale 1ns/1ps
module lsu_decode
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 2
) (
  input  logic [OPC_W-1:0]  opc,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] base_val,
  output lsu_kind_t         kind,
  output logic [DATA_W-1:0] imm_ext,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              misalign
);
  logic [DATA_W-1:0] addr_sum;
  logic              unused_hi;

  assign imm_ext   = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign addr_sum  = base_val + imm_ext;
  assign eff_addr  = addr_sum[ADDR_W-1:0];
  assign unused_hi = ^addr_sum[DATA_W-1:ADDR_W];

  always_comb begin
    kind = '0;
    case (opc)
      OPC_MOVI: kind.is_mov = 1'b1;
      OPC_LDB:  begin kind.is_load  = 1'b1; kind.size = SZ_BYTE; end
      OPC_LDH:  begin kind.is_load  = 1'b1; kind.size = SZ_HALF; end
      OPC_LDW:  begin kind.is_load  = 1'b1; kind.size = SZ_WORD; end
      OPC_STB:  begin kind.is_store = 1'b1; kind.size = SZ_BYTE; end
      OPC_STH:  begin kind.is_store = 1'b1; kind.size = SZ_HALF; end
      OPC_STW:  begin kind.is_store = 1'b1; kind.size = SZ_WORD; end
      default:  ;
    endcase
  end

  always_comb begin
    case (kind.size)
      SZ_HALF: misalign = eff_addr[0];
      SZ_WORD: misalign = |eff_addr[OFF_W-1:0];
      default: misalign = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_lane_pack.sv
`timescale 1ns/1ps
module lsu_lane_pack
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  lsu_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] data,
  output logic [NB-1:0]     be,
  output logic [DATA_W-1:0] wdata
);
  int span;

  always_comb begin
    case (size)
      SZ_BYTE: span = 1;
      SZ_HALF: span = 2;
      default: span = NB;
    endcase
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign be[g] = (g >= int'(off)) && (g < int'(off) + span);
  end

  assign wdata = data << (8 * off);
endmodule

// File: rtl/lsu_load_extract.sv
`timescale 1ns/1ps
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  lsu_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] value
);
  logic [DATA_W-1:0] shifted;

  assign shifted = rdata >> (8 * off);

  always_comb begin
    case (size)
      SZ_BYTE: value = {{(DATA_W-8){1'b0}}, shifted[7:0]};
      SZ_HALF: value = {{(DATA_W-16){1'b0}}, shifted[15:0]};
      default: value = shifted;
    endcase
  end
endmodule

// File: rtl/lsu_core.sv
`timescale 1ns/1ps
module lsu_core
  import lsu_pkg::*;
#(
  parameter int  DATA_W    = 32,
  parameter int  MEM_BYTES = 4096,
  localparam int NB        = DATA_W / 8,
  localparam int OFF_W     = $clog2(NB),
  localparam int ADDR_W    = $clog2(MEM_BYTES),
  localparam int WADDR_W   = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr_word,
  output logic [RIDX_W-1:0]  rf_base_idx,
  output logic [RIDX_W-1:0]  rf_data_idx,
  input  logic [DATA_W-1:0]  rf_base_val,
  input  logic [DATA_W-1:0]  rf_data_val,
  output logic               rf_wr_en,
  output logic [RIDX_W-1:0]  rf_wr_idx,
  output logic [DATA_W-1:0]  rf_wr_val,
  output logic               mem_en,
  output logic               mem_we,
  output logic [NB-1:0]      mem_be,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               trap_misalign
);
  lsu_kind_t         kind;
  logic [DATA_W-1:0] imm_ext;
  logic [ADDR_W-1:0] eff_addr;
  logic              misalign;
  logic [NB-1:0]     lane_be;
  logic [DATA_W-1:0] lane_wdata;
  logic [DATA_W-1:0] load_val;
  logic              acc_mem;

  // stage 1: request issued, stage 2: read data returning
  logic              s1_wb, s2_wb;
  logic              s1_ld, s2_ld;
  lsu_size_e         s1_size, s2_size;
  logic [OFF_W-1:0]  s1_off, s2_off;
  logic [RIDX_W-1:0] s1_idx, s2_idx;
  logic [DATA_W-1:0] s1_mval, s2_mval;

  assign rf_base_idx = instr_word[25:21];
  assign rf_data_idx = instr_word[20:16];

  lsu_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) dec_i (
    .opc      (instr_word[31:26]),
    .imm      (instr_word[15:0]),
    .base_val (rf_base_val),
    .kind     (kind),
    .imm_ext  (imm_ext),
    .eff_addr (eff_addr),
    .misalign (misalign)
  );

  lsu_lane_pack #(.DATA_W(DATA_W)) pack_i (
    .size  (kind.size),
    .off   (eff_addr[OFF_W-1:0]),
    .data  (rf_data_val),
    .be    (lane_be),
    .wdata (lane_wdata)
  );

  lsu_load_extract #(.DATA_W(DATA_W)) ext_i (
    .size  (s2_size),
    .off   (s2_off),
    .rdata (mem_rdata),
    .value (load_val)
  );

  assign acc_mem = instr_valid && (kind.is_load || kind.is_store);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en        <= 1'b0;
      mem_we        <= 1'b0;
      mem_be        <= '0;
      mem_addr      <= '0;
      mem_wdata     <= '0;
      trap_misalign <= 1'b0;
      s1_wb         <= 1'b0;
      s1_ld         <= 1'b0;
      s1_size       <= SZ_BYTE;
      s1_off        <= '0;
      s1_idx        <= '0;
      s1_mval       <= '0;
    end else begin
      mem_en        <= acc_mem && !misalign;
      mem_we        <= acc_mem && !misalign && kind.is_store;
      mem_be        <= lane_be;
      mem_addr      <= eff_addr[ADDR_W-1:OFF_W];
      mem_wdata     <= lane_wdata;
      trap_misalign <= acc_mem && misalign;
      s1_wb         <= instr_valid && (kind.is_mov || (kind.is_load && !misalign));
      s1_ld         <= kind.is_load;
      s1_size       <= kind.size;
      s1_off        <= eff_addr[OFF_W-1:0];
      s1_idx        <= rf_data_idx;
      s1_mval       <= imm_ext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_wb   <= 1'b0;
      s2_ld   <= 1'b0;
      s2_size <= SZ_BYTE;
      s2_off  <= '0;
      s2_idx  <= '0;
      s2_mval <= '0;
    end else begin
      s2_wb   <= s1_wb;
      s2_ld   <= s1_ld;
      s2_size <= s1_size;
      s2_off  <= s1_off;
      s2_idx  <= s1_idx;
      s2_mval <= s1_mval;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_wr_en  <= 1'b0;
      rf_wr_idx <= '0;
      rf_wr_val <= '0;
    end else begin
      rf_wr_en  <= s2_wb;
      rf_wr_idx <= s2_idx;
      rf_wr_val <= s2_ld ? load_val : s2_mval;
    end
  end
endmodule

// File: rtl/lsu_core_chk.sv
`timescale 1ns/1ps
module lsu_core_chk #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          instr_valid,
  input logic [5:0]    opc,
  input logic          mem_en,
  input logic          mem_we,
  input logic [NB-1:0] mem_be,
  input logic          trap_misalign,
  input logic          rf_wr_en
);
  // R7
  trap_excl_chk: assert property (@(posedge clk) disable iff (rst)
    trap_misalign |-> !mem_en);

  // R7
  trap_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    trap_misalign |-> ##2 !rf_wr_en);

  // R6
  store_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                            $countones(mem_be) == NB));

  // R3
  mov_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && opc == 6'd16) |=> (!mem_en && !trap_misalign));

  // R2
  mem_op_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && opc >= 6'd17 && opc <= 6'd22) |=> (mem_en != trap_misalign));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> (!mem_en && !trap_misalign));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_en && !trap_misalign && !rf_wr_en));
endmodule

bind lsu_core lsu_core_chk #(.NB(NB)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .instr_valid   (instr_valid),
  .opc           (instr_word[31:26]),
  .mem_en        (mem_en),
  .mem_we        (mem_we),
  .mem_be        (mem_be),
  .trap_misalign (trap_misalign),
  .rf_wr_en      (rf_wr_en)
);

// File: tb/lsu_core_tb_top.sv
`timescale 1ns/1ps
module lsu_core_tb_top;
  localparam int MEMB = 4096;
  localparam logic [5:0] OP_MOV = 6'd16, OP_LB = 6'd17, OP_LH = 6'd18, OP_LW = 6'd19;
  localparam logic [5:0] OP_SB = 6'd20, OP_SH = 6'd21, OP_SW = 6'd22;

  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid;
  logic [31:0] instr_word;
  logic [4:0]  rf_base_idx, rf_data_idx, rf_wr_idx;
  logic [31:0] rf_base_val, rf_data_val, rf_wr_val;
  logic        rf_wr_en, mem_en, mem_we, trap_misalign;
  logic [3:0]  mem_be;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  lsu_core dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .rf_base_idx(rf_base_idx), .rf_data_idx(rf_data_idx),
    .rf_base_val(rf_base_val), .rf_data_val(rf_data_val),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_val(rf_wr_val),
    .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .trap_misalign(trap_misalign)
  );

  // environment: register file and data memory seen by the design
  logic [31:0] rf_arr [32];
  logic [7:0]  dmem [MEMB];
  // reference state built from the requirements
  logic [31:0] exp_rf [32];
  logic [7:0]  emem [MEMB];

  assign rf_base_val = rf_arr[rf_base_idx];
  assign rf_data_val = rf_arr[rf_data_idx];

  always @(posedge clk) begin
    if (rf_wr_en) rf_arr[rf_wr_idx] <= rf_wr_val;
    if (mem_en) begin
      if (mem_we) begin
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) dmem[int'(mem_addr) * 4 + l] = mem_wdata[8*l +: 8];
      end else begin
        mem_rdata <= {dmem[int'(mem_addr)*4+3], dmem[int'(mem_addr)*4+2],
                      dmem[int'(mem_addr)*4+1], dmem[int'(mem_addr)*4]};
      end
    end
  end

  typedef struct {
    logic        trap;
    logic        men;
    logic        mwe;
    logic [9:0]  addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    string       tag;
  } req_item_t;

  typedef struct {
    int          due;
    logic [4:0]  idx;
    logic [31:0] val;
    string       tag;
  } wb_item_t;

  req_item_t req_q[$];
  wb_item_t  wb_q[$];
  int  cyc = 0;
  int  n_chk = 0;
  int  n_fail = 0;
  bit  sb_on = 1'b0;
  bit  done = 1'b0;

  function automatic logic [7:0] pat(int i);
    return 8'(i * 37 + 5);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] op, input int a, input int b,
                       input logic [15:0] imm, input bit vld, input string tag);
    req_item_t   it;
    wb_item_t    w;
    logic [31:0] sx, base, dat, v;
    logic [11:0] ea;
    int          sz;
    bit          legal, ismov, isld, isst, mis;
    @(negedge clk);
    instr_valid = vld;
    instr_word  = {op, 5'(a), 5'(b), imm};
    sx    = {{16{imm[15]}}, imm};
    base  = exp_rf[a];
    dat   = exp_rf[b];
    ea    = 12'(base + sx);
    legal = vld && op >= OP_MOV && op <= OP_SW;
    ismov = op == OP_MOV;
    isld  = op >= OP_LB && op <= OP_LW;
    isst  = op >= OP_SB && op <= OP_SW;
    sz    = (op == OP_LB || op == OP_SB) ? 1 : (op == OP_LH || op == OP_SH) ? 2 : 4;
    mis   = (sz == 2 && ea[0]) || (sz == 4 && ea[1:0] != 2'b00);
    it.trap  = legal && !ismov && mis;
    it.men   = legal && !ismov && !mis;
    it.mwe   = isst;
    it.addr  = ea[11:2];
    it.be    = 4'(((1 << sz) - 1) << ea[1:0]);
    it.wdata = dat << (8 * ea[1:0]);
    it.tag   = tag;
    req_q.push_back(it);
    if (legal && ismov) begin
      exp_rf[b] = sx;
      w.due = cyc + 3; w.idx = 5'(b); w.val = sx; w.tag = tag;
      wb_q.push_back(w);
    end
    if (legal && isld && !mis) begin
      v = '0;
      for (int k = 0; k < sz; k++) v = v | (32'(emem[int'(ea) + k]) << (8 * k));
      exp_rf[b] = v;
      w.due = cyc + 3; w.idx = 5'(b); w.val = v; w.tag = tag;
      wb_q.push_back(w);
    end
    if (legal && isst && !mis)
      for (int k = 0; k < sz; k++) emem[int'(ea) + k] = dat[8*k +: 8];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(OP_LW, 1, 2, 16'h0000, 1'b0, "R8");
  endtask

  // monitor: compares design results against the queued expectations
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      if (sb_on) begin
        if (req_q.size() > 0) begin
          req_item_t e;
          e = req_q.pop_front();
          check(trap_misalign == e.trap, e.tag, "trap_misalign", 32'(trap_misalign), 32'(e.trap));
          check(mem_en == e.men, e.tag, "mem_en", 32'(mem_en), 32'(e.men));
          if (e.men && mem_en) begin
            logic [31:0] msk;
            check(mem_we == e.mwe, e.tag, "mem_we", 32'(mem_we), 32'(e.mwe));
            check(mem_addr == e.addr, e.tag, "mem_addr", 32'(mem_addr), 32'(e.addr));
            if (e.mwe) begin
              msk = '0;
              for (int l = 0; l < 4; l++) if (e.be[l]) msk[8*l +: 8] = 8'hFF;
              check(mem_be == e.be, e.tag, "mem_be", 32'(mem_be), 32'(e.be));
              check((mem_wdata & msk) == (e.wdata & msk), e.tag, "mem_wdata",
                    mem_wdata & msk, e.wdata & msk);
            end
          end
        end
        if (rf_wr_en) begin
          if (wb_q.size() == 0) begin
            check(1'b0, "R8", "unexpected rf write idx", 32'(rf_wr_idx), 32'hFFFF_FFFF);
          end else begin
            wb_item_t w;
            w = wb_q.pop_front();
            check(cyc == w.due, "R10", "write cycle", 32'(cyc), 32'(w.due));
            check(rf_wr_idx == w.idx, w.tag, "rf_wr_idx", 32'(rf_wr_idx), 32'(w.idx));
            check(rf_wr_val == w.val, w.tag, "rf_wr_val", rf_wr_val, w.val);
          end
        end else if (wb_q.size() > 0 && cyc >= wb_q[0].due) begin
          wb_item_t w;
          w = wb_q.pop_front();
          check(1'b0, w.tag, "missing rf write val", 32'(rf_wr_en), w.val);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEMB; i++) begin
      dmem[i] = pat(i);
      emem[i] = pat(i);
    end
    for (int i = 0; i < 32; i++) begin
      rf_arr[i] = '0;
      exp_rf[i] = '0;
    end
    mem_rdata   = '0;
    rst         = 1'b1;
    instr_valid = 1'b0;
    instr_word  = '0;
    repeat (3) @(negedge clk);
    // R9 reset values
    check(rf_wr_en == 1'b0, "R9", "rf_wr_en in reset", 32'(rf_wr_en), 0);
    check(mem_en == 1'b0, "R9", "mem_en in reset", 32'(mem_en), 0);
    check(trap_misalign == 1'b0, "R9", "trap in reset", 32'(trap_misalign), 0);
    check(mem_we == 1'b0 && mem_be == 4'h0, "R9", "mem_we/be in reset", {mem_we, mem_be}, 0);
    rst   = 1'b0;
    sb_on = 1'b1;

    // R1 field positions, checked in the driving cycle
    issue(OP_LW, 7, 12, 16'h0040, 1'b0, "R8");
    #0.5;
    check(rf_base_idx == 5'd7, "R1", "rf_base_idx", 32'(rf_base_idx), 7);
    check(rf_data_idx == 5'd12, "R1", "rf_data_idx", 32'(rf_data_idx), 12);

    // R3 / R10: back-to-back moves, positive and negative immediates
    issue(OP_MOV, 0, 1, 16'h0100, 1'b1, "R3");
    issue(OP_MOV, 0, 2, 16'hFFFE, 1'b1, "R3");
    issue(OP_MOV, 0, 4, 16'h7FFF, 1'b1, "R3");
    issue(OP_MOV, 0, 5, 16'hA5C3, 1'b1, "R3");
    issue(OP_MOV, 0, 6, 16'h5A7E, 1'b1, "R3");
    idle(3);

    // R6 stores on every lane width, R2 negative offset
    issue(OP_SW, 1, 5, 16'h0000, 1'b1, "R6");
    issue(OP_SB, 1, 6, 16'h0005, 1'b1, "R6");
    issue(OP_SH, 1, 5, 16'h0006, 1'b1, "R6");
    issue(OP_SB, 1, 6, 16'hFFFF, 1'b1, "R2");
    issue(OP_SH, 1, 6, 16'h000A, 1'b1, "R6");

    // R4 / R5 loads with zero extension
    issue(OP_LW, 1, 7, 16'h0000, 1'b1, "R5");
    issue(OP_LB, 1, 8, 16'h0005, 1'b1, "R4");
    issue(OP_LH, 1, 9, 16'h0006, 1'b1, "R5");
    issue(OP_LB, 1, 10, 16'hFFFF, 1'b1, "R4");
    issue(OP_LB, 1, 11, 16'h0003, 1'b1, "R4");
    issue(OP_LH, 1, 12, 16'h0002, 1'b1, "R5");
    issue(OP_LH, 1, 21, 16'h0008, 1'b1, "R5");
    issue(OP_LW, 0, 13, 16'h0200, 1'b1, "R5");
    // R2 address wrap above 4 KB and below zero
    issue(OP_LW, 2, 14, 16'h0006, 1'b1, "R2");
    issue(OP_LB, 4, 15, 16'h0001, 1'b1, "R2");
    issue(OP_LW, 2, 16, 16'h0002, 1'b1, "R2");

    // R7 misaligned accesses: trap, no access, no write
    issue(OP_LH, 1, 17, 16'h0001, 1'b1, "R7");
    issue(OP_LW, 1, 18, 16'h0002, 1'b1, "R7");
    issue(OP_LW, 1, 18, 16'h0001, 1'b1, "R7");
    issue(OP_SW, 1, 6, 16'h0001, 1'b1, "R7");
    issue(OP_SH, 1, 6, 16'h0003, 1'b1, "R7");
    issue(OP_SB, 1, 6, 16'h0003, 1'b1, "R6");
    // memory behind the trapped stores is unchanged except the byte store
    issue(OP_LW, 1, 19, 16'h0000, 1'b1, "R7");

    // R8 other opcodes and invalid cycles
    issue(6'd3, 1, 22, 16'h0000, 1'b1, "R8");
    issue(6'd23, 1, 6, 16'h0000, 1'b1, "R8");
    issue(OP_MOV, 0, 23, 16'h1111, 1'b0, "R8");
    issue(OP_SW, 1, 6, 16'h0000, 1'b0, "R8");
    issue(6'd63, 1, 24, 16'h0000, 1'b1, "R8");
    idle(3);
    // R8 the invalid store left memory intact, the invalid move left r23
    issue(OP_LW, 1, 25, 16'h0000, 1'b1, "R8");
    issue(OP_SW, 0, 23, 16'h0300, 1'b1, "R8");
    idle(1);
    issue(OP_LW, 0, 26, 16'h0300, 1'b1, "R8");

    // R10 store followed at once by a load of the same word, mixed writes
    issue(OP_SW, 1, 6, 16'h0010, 1'b1, "R10");
    issue(OP_LW, 1, 20, 16'h0010, 1'b1, "R10");
    issue(OP_MOV, 0, 27, 16'h8000, 1'b1, "R10");
    issue(OP_LB, 1, 28, 16'h0011, 1'b1, "R10");
    issue(OP_MOV, 0, 29, 16'h0001, 1'b1, "R10");
    idle(6);

    check(wb_q.size() == 0, "R10", "pending writes", 32'(wb_q.size()), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule